// File: doc/BRIEF.md
# Wait-Instruction Clock Suspend Controller

This block sequences the low-power stop that follows a wait instruction. When the pipeline signals that a wait instruction has reached its memory stage, the controller looks at the bus. If the bus is idle, it freezes the pipeline and removes the enable from the core clock gate. If the bus is busy, it holds the pipeline stalled with the core clock still running until the bus drains, and only then suspends. A separate enable for the timer and the input-sampling logic stays high the whole time. This lets those parts keep counting and keep watching the interrupt, NMI, reset and debug-interrupt pins.

The states are RUN, WAIT_BUS, SUSPENDED and WAKE. The transitions are:
- RUN to SUSPENDED on a wait with the bus idle.
- RUN to WAIT_BUS on a wait with the bus busy.
- WAIT_BUS to SUSPENDED once the bus goes idle.
- WAIT_BUS to RUN when a wake cause aborts the suspension.
- SUSPENDED to WAKE on an enabled interrupt, an NMI or a debug interrupt.
- WAKE to RUN on the next cycle.
- Any state to RUN on warm or cold reset.

In RUN, a wait that arrives while a wake cause is already present is ignored. In WAKE the core clock runs again while the stall is still held, which gives the pipeline one clocked cycle before it is released. The core clock enable is registered on the falling clock edge, so it only changes while the clock is low.

Top module: `wait_suspend_ctrl`

## Requirements
- R1: While `rst_n` is low, `pipe_stall`=0, `core_clk_en`=1 and `free_clk_en`=0. From the first rising edge after release, the block is in RUN.
- R2: In RUN, `wait_at_mem`=1 with `bus_idle`=1 and no wake cause moves to SUSPENDED after one edge, where `pipe_stall`=1 and `core_clk_en`=0.
- R3: In RUN, `wait_at_mem`=1 with `bus_idle`=0 and no wake cause moves to WAIT_BUS, where `pipe_stall`=1 and `core_clk_en`=1. The block stays there while the bus is busy and enters SUSPENDED on the edge where `bus_idle`=1.
- R4: `free_clk_en` is 1 in every state once the first edge after reset has passed.
- R5: In SUSPENDED, an interrupt bit `irq[i]`=1 with `irq_en[i]`=1 moves to WAKE, where `pipe_stall`=1 and `core_clk_en`=1. WAKE always moves to RUN on the next edge, where `pipe_stall`=0.
- R6: An interrupt bit with `irq_en[i]`=0 has no effect in SUSPENDED. `pipe_stall` stays 1 and `core_clk_en` stays 0.
- R7: In SUSPENDED, `nmi`=1 or `dbg_int`=1 wakes the core through WAKE, as in R5.
- R8: `warm_rst`=1 or `cold_rst`=1 returns the block to RUN on the next edge from any state, skipping WAKE.
- R9: A wake cause seen in WAIT_BUS returns the block to RUN. A wait seen in RUN together with a wake cause leaves the block in RUN.
- R10: `core_clk_en` changes value only while `clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wait_at_mem | input | 1 | Wait instruction is at the memory stage |
| bus_idle | input | 1 | No bus transaction outstanding |
| irq | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Per-line interrupt enable |
| nmi | input | 1 | Non-maskable interrupt |
| warm_rst | input | 1 | Warm reset request |
| cold_rst | input | 1 | Cold reset request |
| dbg_int | input | 1 | Debug interrupt request |
| pipe_stall | output | 1 | Freeze the pipeline |
| core_clk_en | output | 1 | Enable for the core clock gate, updated on the falling edge |
| free_clk_en | output | 1 | Enable for the timer and input-sampling logic |

## Verification
The bench builds the block with the default of six interrupt lines. This puts both an enabled line and a masked line within reach in the same SUSPENDED episode, and lets wakes come from both the lowest and the highest line. A vector table walks every named transition, one cycle per entry. The wait-bus wait is held over several busy cycles, and the two abort paths are covered. Directed tests cover the reset values, a block reset while suspended, and a monitor that flags any change of the core clock enable while the clock is high.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_WAIT_BUS = 2'd1,
        ST_SUSP     = 2'd2,
        ST_WAKE     = 2'd3
    } wsc_state_e;
endpackage

// File: rtl/wsc_wake_merge.sv
module wsc_wake_merge #(
    parameter int NUM_IRQ = 6
) (
    input  logic [NUM_IRQ-1:0] irq,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               nmi,
    input  logic               warm_rst,
    input  logic               cold_rst,
    input  logic               dbg_int,
    output logic               wake_any,
    output logic               rst_any
);
    logic [NUM_IRQ-1:0] irq_live;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
        assign irq_live[i] = irq[i] & irq_en[i];
    end

    assign rst_any  = warm_rst | cold_rst;
    assign wake_any = (|irq_live) | nmi | dbg_int | rst_any;
endmodule

// File: rtl/wsc_fsm.sv
module wsc_fsm
    import wsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wait_at_mem,
    input  logic       bus_idle,
    input  logic       wake_any,
    input  logic       rst_any,
    output wsc_state_e state,
    output logic       stall,
    output logic       core_en_req
);
    wsc_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (wait_at_mem && !wake_any)
                    state_nx = bus_idle ? ST_SUSP : ST_WAIT_BUS;
            end
            ST_WAIT_BUS: begin
                if (wake_any)      state_nx = ST_RUN;
                else if (bus_idle) state_nx = ST_SUSP;
            end
            ST_SUSP: begin
                if (rst_any)       state_nx = ST_RUN;
                else if (wake_any) state_nx = ST_WAKE;
            end
            ST_WAKE:               state_nx = ST_RUN;
            default:               state_nx = ST_RUN;
        endcase
        if (rst_any) state_nx = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        stall       = 1'b0;
        core_en_req = 1'b1;
        unique case (state)
            ST_RUN:      begin stall = 1'b0; core_en_req = 1'b1; end
            ST_WAIT_BUS: begin stall = 1'b1; core_en_req = 1'b1; end
            ST_SUSP:     begin stall = 1'b1; core_en_req = 1'b0; end
            ST_WAKE:     begin stall = 1'b1; core_en_req = 1'b1; end
            default:     begin stall = 1'b0; core_en_req = 1'b1; end
        endcase
    end
endmodule

// File: rtl/wsc_gate_en.sv
module wsc_gate_en (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    output logic en_low
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_low <= 1'b1;
        else        en_low <= en_req;
    end
endmodule

// File: rtl/wait_suspend_ctrl.sv
module wait_suspend_ctrl
    import wsc_pkg::*;
#(
    parameter int NUM_IRQ = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wait_at_mem,
    input  logic               bus_idle,
    input  logic [NUM_IRQ-1:0] irq,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               nmi,
    input  logic               warm_rst,
    input  logic               cold_rst,
    input  logic               dbg_int,
    output logic               pipe_stall,
    output logic               core_clk_en,
    output logic               free_clk_en
);
    logic       wake_any;
    logic       rst_any;
    logic       core_en_req;
    wsc_state_e state_q;

    wsc_wake_merge #(.NUM_IRQ(NUM_IRQ)) u_merge (
        .irq      (irq),
        .irq_en   (irq_en),
        .nmi      (nmi),
        .warm_rst (warm_rst),
        .cold_rst (cold_rst),
        .dbg_int  (dbg_int),
        .wake_any (wake_any),
        .rst_any  (rst_any)
    );

    wsc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wait_at_mem (wait_at_mem),
        .bus_idle    (bus_idle),
        .wake_any    (wake_any),
        .rst_any     (rst_any),
        .state       (state_q),
        .stall       (pipe_stall),
        .core_en_req (core_en_req)
    );

    wsc_gate_en u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_req (core_en_req),
        .en_low (core_clk_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) free_clk_en <= 1'b0;
        else        free_clk_en <= 1'b1;
    end
endmodule

// File: rtl/wait_suspend_ctrl_chk.sv
module wait_suspend_ctrl_chk
    import wsc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_idle,
    input logic       wake_any,
    input logic       rst_any,
    input wsc_state_e state_q,
    input logic       pipe_stall,
    input logic       core_clk_en,
    input logic       free_clk_en
);
    AST_GATED_IMPLIES_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> pipe_stall); // R2

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_BUS && !bus_idle && !wake_any) |=> (state_q == ST_WAIT_BUS)); // R3

    AST_FREE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_stall |-> free_clk_en); // R4

    AST_WAKE_THEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE) |=> !pipe_stall); // R5

    AST_QUIET_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP && !wake_any) |=> (state_q == ST_SUSP)); // R6

    AST_RESET_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_any |=> (state_q == ST_RUN)); // R8

    AST_ABORT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_BUS && wake_any) |=> !pipe_stall); // R9
endmodule

bind wait_suspend_ctrl wait_suspend_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_idle    (bus_idle),
    .wake_any    (wake_any),
    .rst_any     (rst_any),
    .state_q     (state_q),
    .pipe_stall  (pipe_stall),
    .core_clk_en (core_clk_en),
    .free_clk_en (free_clk_en)
);

// File: tb/sim_wait_suspend_ctrl.sv
`timescale 1ns/1ps
module sim_wait_suspend_ctrl;
    localparam int NIRQ = 6;
    localparam int NVEC = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wait_at_mem = 1'b0, bus_idle = 1'b1;
    logic [NIRQ-1:0] irq = '0, irq_en = '1;
    logic nmi = 1'b0, warm_rst = 1'b0, cold_rst = 1'b0, dbg_int = 1'b0;
    logic pipe_stall, core_clk_en, free_clk_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wait_suspend_ctrl #(.NUM_IRQ(NIRQ)) u0 (
        .clk(clk), .rst_n(rst_n), .wait_at_mem(wait_at_mem), .bus_idle(bus_idle),
        .irq(irq), .irq_en(irq_en), .nmi(nmi), .warm_rst(warm_rst),
        .cold_rst(cold_rst), .dbg_int(dbg_int), .pipe_stall(pipe_stall),
        .core_clk_en(core_clk_en), .free_clk_en(free_clk_en)
    );

    // {wait, idle, irq[5:0], irq_en[5:0], nmi, warm, cold, dbg, exp_stall, exp_en}
    localparam logic [19:0] VEC [0:NVEC-1] = '{
        {1'b0, 1'b1, 6'h00, 6'h3F, 4'b0000, 2'b01}, // 0  RUN
        {1'b1, 1'b1, 6'h00, 6'h3F, 4'b0000, 2'b10}, // 1  R2 -> SUSP
        {1'b0, 1'b1, 6'h00, 6'h3F, 4'b0000, 2'b10}, // 2  stay SUSP
        {1'b0, 1'b1, 6'h01, 6'h3F, 4'b0000, 2'b11}, // 3  R5 irq0 -> WAKE
        {1'b0, 1'b1, 6'h00, 6'h3F, 4'b0000, 2'b01}, // 4  R5 WAKE -> RUN
        {1'b1, 1'b0, 6'h00, 6'h3F, 4'b0000, 2'b11}, // 5  R3 -> WAIT_BUS
        {1'b0, 1'b0, 6'h00, 6'h3F, 4'b0000, 2'b11}, // 6  R3 busy hold
        {1'b0, 1'b1, 6'h00, 6'h3F, 4'b0000, 2'b10}, // 7  R3 idle -> SUSP
        {1'b0, 1'b1, 6'h04, 6'h3B, 4'b0000, 2'b10}, // 8  R6 masked irq2
        {1'b0, 1'b1, 6'h00, 6'h3F, 4'b1000, 2'b11}, // 9  R7 nmi -> WAKE
        {1'b0, 1'b1, 6'h00, 6'h3F, 4'b0000, 2'b01}, // 10 RUN
        {1'b1, 1'b0, 6'h00, 6'h3F, 4'b0000, 2'b11}, // 11 WAIT_BUS
        {1'b0, 1'b0, 6'h00, 6'h3F, 4'b0001, 2'b01}, // 12 R9 abort by dbg
        {1'b1, 1'b1, 6'h00, 6'h3F, 4'b0000, 2'b10}, // 13 SUSP
        {1'b0, 1'b1, 6'h00, 6'h3F, 4'b0001, 2'b11}, // 14 R7 dbg -> WAKE
        {1'b0, 1'b1, 6'h00, 6'h3F, 4'b0000, 2'b01}, // 15 RUN
        {1'b1, 1'b1, 6'h00, 6'h3F, 4'b0000, 2'b10}, // 16 SUSP
        {1'b0, 1'b1, 6'h00, 6'h3F, 4'b0010, 2'b01}, // 17 R8 cold -> RUN
        {1'b1, 1'b1, 6'h00, 6'h3F, 4'b0000, 2'b10}, // 18 SUSP
        {1'b0, 1'b1, 6'h00, 6'h3F, 4'b0100, 2'b01}, // 19 R8 warm -> RUN
        {1'b1, 1'b1, 6'h20, 6'h3F, 4'b0000, 2'b01}, // 20 R9 wait + irq5
        {1'b1, 1'b0, 6'h00, 6'h3F, 4'b0000, 2'b11}, // 21 WAIT_BUS
        {1'b0, 1'b0, 6'h02, 6'h3F, 4'b0000, 2'b01}  // 22 R9 abort by irq1
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply(input logic [19:0] v);
        wait_at_mem = v[19];
        bus_idle    = v[18];
        irq         = v[17:12];
        irq_en      = v[11:6];
        nmi         = v[5];
        warm_rst    = v[4];
        cold_rst    = v[3];
        dbg_int     = v[2];
    endtask

    // R10: enable may only move while clk is low
    always @(core_clk_en) begin
        if (rst_n && $time > 0) chk("R10 core_clk_en edge clk", clk, 1'b0);
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #7;
        chk("R1 stall in reset", pipe_stall, 1'b0);
        chk("R1 core_clk_en in reset", core_clk_en, 1'b1);
        chk("R1 free_clk_en in reset", free_clk_en, 1'b0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(posedge clk); #3;
        chk("R1 free_clk_en after edge", free_clk_en, 1'b1);
        chk("R1 run after reset", pipe_stall, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i]);
            @(posedge clk); #3;
            chk($sformatf("R2-vec%0d stall", i), pipe_stall, VEC[i][1]);
            chk($sformatf("R3-vec%0d core_clk_en", i), core_clk_en, VEC[i][0]);
            chk($sformatf("R4 vec%0d free_clk_en", i), free_clk_en, 1'b1);
        end

        // R1: block reset while suspended
        apply({1'b1, 1'b1, 6'h00, 6'h3F, 4'b0000, 2'b00});
        @(posedge clk); #3;
        chk("R2 suspended before block reset", core_clk_en, 1'b0);
        apply({1'b0, 1'b1, 6'h00, 6'h3F, 4'b0000, 2'b00});
        rst_n = 1'b0;
        #1;
        chk("R1 reset clears stall", pipe_stall, 1'b0);
        chk("R1 reset raises core_clk_en", core_clk_en, 1'b1);
        @(posedge clk); #1 rst_n = 1'b1;
        @(posedge clk); #3;
        chk("R1 run after second reset", pipe_stall, 1'b0);

        // R6: every line masked, all requests high, stays asleep for several cycles
        apply({1'b1, 1'b1, 6'h00, 6'h3F, 4'b0000, 2'b00});
        @(posedge clk); #3;
        apply({1'b0, 1'b1, 6'h3F, 6'h00, 4'b0000, 2'b00});
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #3;
            chk("R6 all masked stall", pipe_stall, 1'b1);
            chk("R6 all masked core_clk_en", core_clk_en, 1'b0);
        end
        apply({1'b0, 1'b1, 6'h20, 6'h20, 4'b0000, 2'b00});
        @(posedge clk); #3;
        chk("R5 irq5 enabled wakes", core_clk_en, 1'b1);
        @(posedge clk); #3;
        chk("R5 release after wake", pipe_stall, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule